// File: doc/BRIEF.md
# CAN Interrupt and Fault-Confinement Unit

This block gathers every interrupt source of a CAN controller into one status word and a single interrupt line. Two groups of sources feed it. The mailbox group has a data-ready bit and a send-aborted bit for each mailbox; both follow their inputs, which come from mailbox storage. The system group covers the node's error condition, wake-up, sleep and the internal timer.

The block classifies the node's fault-confinement state from the transmit and receive error counters as error active, error passive or bus off. It also reports a warning level. A sleep request is reported only once no mailbox still has a transmission pending. A wake-up is reported only when bus synchronisation follows an earlier wake-up event. A timer wrap is reported for one cycle.

A mask register selects which status bits reach the interrupt output. The host changes the mask through separate set and clear ports, and it can read the mask back. The status word always shows the raw state of every source, whatever the mask.

Top module: `can_irq_unit`

Status word layout, with N mailboxes: bits [N-1:0] are data-ready, bits [2N-1:N] are send-aborted, and the system bits start at S = 2N. The system bits are S+0 error active, S+1 warning, S+2 error passive, S+3 bus off, S+4 sleep, S+5 wake-up and S+6 timer wrap.

## Requirements
- R1: While reset is applied and right after it, the mask is all zero and `irq` is 0. The status word is zero except S+0 (error active), which is 1.
- R2: Status bits [N-1:0] and [2N-1:N] equal `mb_ready` and `mb_abort` as sampled at the previous rising clock edge.
- R3: A 1 on a bit of `mask_set` sets that mask bit, and a 1 on a bit of `mask_clr` clears it. The change shows on `mask` after the next edge. When both ports carry a 1 on the same bit, the bit is cleared.
- R4: `irq` is 1 exactly when some status bit and its mask bit are both 1.
- R5: Status bit S+3 (bus off) is 1 when the sampled `tec` is above 255. While it is set, S+2 and S+0 are 0.
- R6: Status bit S+2 (error passive) is 1 when `tec` or `rec` is 128 or more and the node is not bus off.
- R7: Status bit S+0 (error active) is 1 when the node is neither error passive nor bus off. Status bit S+1 (warning) is 1 only while the node is error active and `tec` or `rec` is above 96.
- R8: The status word reports every source whether it is masked or not. A masked source does not drive `irq`.
- R9: Status bit S+4 (sleep) is 1 one cycle after a cycle in which `sleep_req` is 1 and `tx_pending` is all zero. While any pending bit is set, S+4 stays 0.
- R10: Status bit S+5 (wake-up) pulses for one cycle when `bus_sync` arrives after an earlier `wake_evt`. A `bus_sync` with no earlier wake event leaves S+5 at 0.
- R11: Status bit S+6 (timer wrap) is 1 for one cycle following each cycle in which `tmr_wrap` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mb_ready | input | NMB | Per-mailbox data-ready level (received in receive mode, sent in transmit mode) |
| mb_abort | input | NMB | Per-mailbox send-aborted level |
| tx_pending | input | NMB | Per-mailbox transmission still pending |
| tec | input | CNT_W | Transmit error counter |
| rec | input | CNT_W | Receive error counter |
| wake_evt | input | 1 | Wake-up event pulse |
| bus_sync | input | 1 | Bus synchronisation pulse |
| sleep_req | input | 1 | Low-power mode requested |
| tmr_wrap | input | 1 | Internal timer rollover pulse |
| mask_set | input | 2*NMB+7 | Write-one-to-set mask bits |
| mask_clr | input | 2*NMB+7 | Write-one-to-clear mask bits |
| status | output | 2*NMB+7 | Raw status word |
| mask | output | 2*NMB+7 | Current mask |
| irq | output | 1 | Interrupt request |

## Verification
Every status bit is registered, so each one is due exactly one rising edge after its input changes. This holds for the mailbox levels, the counter-derived states, sleep and timer wrap. The wake-up pulse is due one edge after `bus_sync`, provided `wake_evt` arrived at an earlier edge. Mask writes appear on `mask` one edge after the write, and `irq` follows status and mask in that same cycle. The bench drives on the falling edge, steps across exactly one rising edge and samples on the next falling edge. Each check therefore lands in the cycle where the result is first due, and one-cycle pulses are checked again one edge later to confirm they fall.

// File: rtl/can_irq_pkg.sv
package can_irq_pkg;

  localparam int unsigned WARN_LIM = 96;
  localparam int unsigned PASS_LIM = 128;
  localparam int unsigned BOFF_LIM = 255;

  localparam int SYS_ERRA  = 0;
  localparam int SYS_WARN  = 1;
  localparam int SYS_ERRP  = 2;
  localparam int SYS_BOFF  = 3;
  localparam int SYS_SLEEP = 4;
  localparam int SYS_WAKE  = 5;
  localparam int SYS_TOVF  = 6;
  localparam int SYS_N     = 7;

  typedef enum logic [1:0] {
    FC_ACTIVE  = 2'd0,
    FC_PASSIVE = 2'd1,
    FC_BUSOFF  = 2'd2
  } fc_state_e;

  // bus off has priority over error passive
  function automatic fc_state_e fc_classify(input int unsigned t, input int unsigned r);
    if (t > BOFF_LIM) return FC_BUSOFF;
    if (t >= PASS_LIM || r >= PASS_LIM) return FC_PASSIVE;
    return FC_ACTIVE;
  endfunction

  function automatic logic fc_over_warn(input int unsigned t, input int unsigned r);
    return (t > WARN_LIM) || (r > WARN_LIM);
  endfunction

endpackage

// File: rtl/can_fc_tracker.sv
module can_fc_tracker
  import can_irq_pkg::*;
#(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] tec,
  input  logic [CNT_W-1:0] rec,
  output logic             st_active,
  output logic             st_warn,
  output logic             st_passive,
  output logic             st_busoff
);
  fc_state_e state_q, state_nxt;
  logic      warn_q, warn_nxt;

  always_comb begin
    state_nxt = fc_classify(32'(tec), 32'(rec));
    warn_nxt  = (state_nxt == FC_ACTIVE) && fc_over_warn(32'(tec), 32'(rec));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FC_ACTIVE;
      warn_q  <= 1'b0;
    end else begin
      state_q <= state_nxt;
      warn_q  <= warn_nxt;
    end
  end

  assign st_active  = (state_q == FC_ACTIVE);
  assign st_passive = (state_q == FC_PASSIVE);
  assign st_busoff  = (state_q == FC_BUSOFF);
  assign st_warn    = warn_q;
endmodule

// File: rtl/can_sys_events.sv
module can_sys_events #(
  parameter int NMB = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sleep_req,
  input  logic [NMB-1:0] tx_pending,
  input  logic           wake_evt,
  input  logic           bus_sync,
  input  logic           tmr_wrap,
  output logic           sleep_st,
  output logic           wake_st,
  output logic           tovf_st
);
  logic armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q  <= 1'b0;
      sleep_st <= 1'b0;
      wake_st  <= 1'b0;
      tovf_st  <= 1'b0;
    end else begin
      sleep_st <= sleep_req && (tx_pending == '0);
      wake_st  <= armed_q && bus_sync;
      armed_q  <= wake_evt || (armed_q && !bus_sync);
      tovf_st  <= tmr_wrap;
    end
  end
endmodule

// File: rtl/can_irq_mask.sv
module can_irq_mask #(
  parameter int W = 23
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_bits,
  input  logic [W-1:0] clr_bits,
  input  logic [W-1:0] src,
  output logic [W-1:0] mask_q,
  output logic         irq
);
  logic [W-1:0] hit;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           mask_q[i] <= 1'b0;
      else if (clr_bits[i]) mask_q[i] <= 1'b0;
      else if (set_bits[i]) mask_q[i] <= 1'b1;
    end
    assign hit[i] = src[i] & mask_q[i];
  end

  assign irq = |hit;
endmodule

// File: rtl/can_irq_unit.sv
module can_irq_unit
  import can_irq_pkg::*;
#(
  parameter int NMB   = 8,
  parameter int CNT_W = 9,
  localparam int SB   = 2 * NMB,
  localparam int W    = SB + SYS_N
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NMB-1:0]   mb_ready,
  input  logic [NMB-1:0]   mb_abort,
  input  logic [NMB-1:0]   tx_pending,
  input  logic [CNT_W-1:0] tec,
  input  logic [CNT_W-1:0] rec,
  input  logic             wake_evt,
  input  logic             bus_sync,
  input  logic             sleep_req,
  input  logic             tmr_wrap,
  input  logic [W-1:0]     mask_set,
  input  logic [W-1:0]     mask_clr,
  output logic [W-1:0]     status,
  output logic [W-1:0]     mask,
  output logic             irq
);
  logic [NMB-1:0] rdy_q, abt_q;
  logic st_active, st_warn, st_passive, st_busoff;
  logic sleep_st, wake_st, tovf_st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q <= '0;
      abt_q <= '0;
    end else begin
      rdy_q <= mb_ready;
      abt_q <= mb_abort;
    end
  end

  can_fc_tracker #(.CNT_W(CNT_W)) fc_i (
    .clk(clk), .rst_n(rst_n), .tec(tec), .rec(rec),
    .st_active(st_active), .st_warn(st_warn),
    .st_passive(st_passive), .st_busoff(st_busoff)
  );

  can_sys_events #(.NMB(NMB)) sys_i (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .tx_pending(tx_pending),
    .wake_evt(wake_evt), .bus_sync(bus_sync), .tmr_wrap(tmr_wrap),
    .sleep_st(sleep_st), .wake_st(wake_st), .tovf_st(tovf_st)
  );

  always_comb begin
    status                  = '0;
    status[NMB-1:0]         = rdy_q;
    status[SB-1:NMB]        = abt_q;
    status[SB + SYS_ERRA]   = st_active;
    status[SB + SYS_WARN]   = st_warn;
    status[SB + SYS_ERRP]   = st_passive;
    status[SB + SYS_BOFF]   = st_busoff;
    status[SB + SYS_SLEEP]  = sleep_st;
    status[SB + SYS_WAKE]   = wake_st;
    status[SB + SYS_TOVF]   = tovf_st;
  end

  can_irq_mask #(.W(W)) msk_i (
    .clk(clk), .rst_n(rst_n), .set_bits(mask_set), .clr_bits(mask_clr),
    .src(status), .mask_q(mask), .irq(irq)
  );
endmodule

// File: rtl/can_irq_unit_chk.sv
module can_irq_unit_chk
  import can_irq_pkg::*;
#(
  parameter int NMB   = 8,
  parameter int CNT_W = 9,
  localparam int SB   = 2 * NMB,
  localparam int W    = SB + SYS_N
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NMB-1:0]   tx_pending,
  input logic [CNT_W-1:0] tec,
  input logic [CNT_W-1:0] rec,
  input logic             bus_sync,
  input logic             sleep_req,
  input logic             wake_arm,
  input logic [W-1:0]     mask_set,
  input logic [W-1:0]     mask_clr,
  input logic [W-1:0]     status,
  input logic [W-1:0]     mask,
  input logic             irq
);
  assert_mask_clear_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_clr != '0) |=> ((mask & $past(mask_clr)) == '0));

  assert_mask_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((mask_set & ~mask_clr) != '0) |=>
      ((mask & $past(mask_set & ~mask_clr)) == $past(mask_set & ~mask_clr)));

  assert_no_irq_when_masked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !irq);

  assert_busoff_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    status[SB+SYS_BOFF] |-> (!status[SB+SYS_ERRP] && !status[SB+SYS_ERRA]));

  assert_busoff_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[SB+SYS_BOFF]) |-> ($past(tec) > CNT_W'(BOFF_LIM)));

  assert_passive_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[SB+SYS_ERRP]) |->
      ($past(tec) >= CNT_W'(PASS_LIM) || $past(rec) >= CNT_W'(PASS_LIM)));

  assert_one_state_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({status[SB+SYS_ERRA], status[SB+SYS_ERRP], status[SB+SYS_BOFF]}));

  assert_warn_only_active_R7: assert property (@(posedge clk) disable iff (!rst_n)
    status[SB+SYS_WARN] |-> status[SB+SYS_ERRA]);

  assert_sleep_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    status[SB+SYS_SLEEP] |-> $past(sleep_req && (tx_pending == '0)));

  assert_wake_seq_R10: assert property (@(posedge clk) disable iff (!rst_n)
    status[SB+SYS_WAKE] |-> $past(wake_arm && bus_sync));
endmodule

bind can_irq_unit can_irq_unit_chk #(.NMB(NMB), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .tx_pending(tx_pending), .tec(tec), .rec(rec),
  .bus_sync(bus_sync), .sleep_req(sleep_req), .wake_arm(sys_i.armed_q),
  .mask_set(mask_set), .mask_clr(mask_clr), .status(status), .mask(mask), .irq(irq)
);

// File: tb/can_irq_unit_tb_top.sv
`timescale 1ns/1ps
module can_irq_unit_tb_top;
  localparam int NMB = 8;
  localparam int CNT_W = 9;
  localparam int S = 2 * NMB;
  localparam int W = S + 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NMB-1:0] mb_ready = '0, mb_abort = '0, tx_pending = '0;
  logic [CNT_W-1:0] tec = '0, rec = '0;
  logic wake_evt = 1'b0, bus_sync = 1'b0, sleep_req = 1'b0, tmr_wrap = 1'b0;
  logic [W-1:0] mask_set = '0, mask_clr = '0;
  logic [W-1:0] status, mask;
  logic irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  can_irq_unit #(.NMB(NMB), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .mb_ready(mb_ready), .mb_abort(mb_abort),
    .tx_pending(tx_pending), .tec(tec), .rec(rec), .wake_evt(wake_evt),
    .bus_sync(bus_sync), .sleep_req(sleep_req), .tmr_wrap(tmr_wrap),
    .mask_set(mask_set), .mask_clr(mask_clr), .status(status), .mask(mask), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [3:0] model_fc(input int t, input int r);
    logic bo, ep, ea, wn;
    bo = (t >= 256);
    ep = !bo && (t > 127 || r > 127);
    ea = !(bo || ep);
    wn = ea && (t >= 97 || r >= 97);
    return {bo, ep, wn, ea};
  endfunction

  task automatic t_reset();
    logic [W-1:0] e;
    e = '0;
    e[S] = 1'b1;
    check("R1 status in reset", 32'(status), 32'(e));
    check("R1 mask in reset", 32'(mask), 0);
    check("R1 irq in reset", 32'(irq), 0);
    rst_n = 1'b1;
    step();
    check("R1 status after reset", 32'(status), 32'(e));
    check("R1 mask after reset", 32'(mask), 0);
  endtask

  task automatic t_mailbox();
    mb_ready = 8'hA5; mb_abort = 8'h3C;
    step();
    check("R2 ready bits", 32'(status[NMB-1:0]), 32'h A5);
    check("R2 abort bits", 32'(status[S-1:NMB]), 32'h3C);
    mb_ready = 8'h18; mb_abort = 8'h81;
    step();
    check("R2 ready bits second", 32'(status[NMB-1:0]), 32'h18);
    check("R2 abort bits second", 32'(status[S-1:NMB]), 32'h81);
    mb_ready = '0; mb_abort = '0;
    step();
    check("R2 cleared", 32'(status[S-1:0]), 0);
  endtask

  task automatic t_mask();
    mask_set = 23'h00000F;
    step();
    mask_set = '0;
    check("R3 set", 32'(mask), 32'h0F);
    mask_clr = 23'h000005;
    step();
    mask_clr = '0;
    check("R3 clear", 32'(mask), 32'h0A);
    mask_set = 23'h000030; mask_clr = 23'h000022;
    step();
    mask_set = '0; mask_clr = '0;
    check("R3 clear wins", 32'(mask), 32'h18);
    mask_clr = '1;
    step();
    mask_clr = '0;
    check("R3 clear all", 32'(mask), 0);
  endtask

  task automatic t_irq();
    mask_set = 23'h000001;
    step();
    mask_set = '0;
    check("R4 no source", 32'(irq), 0);
    mb_ready = 8'h02;
    step();
    check("R8 masked source visible", 32'(status[NMB-1:0]), 32'h02);
    check("R8 masked source no irq", 32'(irq), 0);
    mb_ready = 8'h01;
    step();
    check("R4 unmasked source irq", 32'(irq), 1);
    mb_ready = '0;
    step();
    check("R4 irq drops", 32'(irq), 0);
    mask_clr = '1;
    step();
    mask_clr = '0;
  endtask

  task automatic t_fc();
    int tv [10] = '{0, 97, 96, 0, 128, 0, 255, 256, 300, 10};
    int rv [10] = '{0, 0, 96, 97, 0, 128, 127, 0, 200, 10};
    for (int k = 0; k < 10; k++) begin
      tec = CNT_W'(tv[k]); rec = CNT_W'(rv[k]);
      step();
      check($sformatf("R5 R6 R7 state tec=%0d rec=%0d", tv[k], rv[k]),
            32'(status[S+3:S]), 32'(model_fc(tv[k], rv[k])));
    end
    mask_set = '0;
    mask_set[S+3] = 1'b1;
    tec = CNT_W'(400);
    step();
    mask_set = '0;
    check("R5 bus off irq", 32'(irq), 1);
    tec = '0; rec = '0;
    step();
    check("R7 back to active", 32'(status[S+3:S]), 32'h1);
    check("R4 bus off irq gone", 32'(irq), 0);
    mask_clr = '1;
    step();
    mask_clr = '0;
  endtask

  task automatic t_sleep();
    tx_pending = 8'h04; sleep_req = 1'b1;
    step();
    check("R9 held while pending", 32'(status[S+4]), 0);
    step();
    check("R9 still held", 32'(status[S+4]), 0);
    tx_pending = '0;
    step();
    check("R9 sleep after drain", 32'(status[S+4]), 1);
    sleep_req = 1'b0;
    step();
    check("R9 sleep released", 32'(status[S+4]), 0);
  endtask

  task automatic t_wake();
    bus_sync = 1'b1;
    step();
    bus_sync = 1'b0;
    check("R10 sync alone", 32'(status[S+5]), 0);
    wake_evt = 1'b1;
    step();
    wake_evt = 1'b0;
    check("R10 event alone", 32'(status[S+5]), 0);
    step();
    bus_sync = 1'b1;
    step();
    bus_sync = 1'b0;
    check("R10 wake after sync", 32'(status[S+5]), 1);
    step();
    check("R10 wake one cycle", 32'(status[S+5]), 0);
  endtask

  task automatic t_timer();
    tmr_wrap = 1'b1;
    step();
    tmr_wrap = 1'b0;
    check("R11 wrap seen", 32'(status[S+6]), 1);
    step();
    check("R11 wrap one cycle", 32'(status[S+6]), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_mailbox();
    t_mask();
    t_irq();
    t_fc();
    t_sleep();
    t_wake();
    t_timer();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog R1: got hang expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule